// File: doc/BRIEF.md
# Linear Systolic MAC Matrix Multiplier

This block multiplies two square matrices of signed fixed-width integers on a one-dimensional chain of multiply-accumulate cells. The default size is 16 by 16, and there is one cell per column of the product. The operands arrive as a single valid/ready stream of (a, b) pairs. Each pair enters the leftmost cell and moves one cell to the right each time the chain steps. Every cell keeps one element of B stationary and accumulates one full column of the product matrix.

A start pulse, taken only while the block is idle, clears all accumulators and opens the operand stream. The chain steps once for every accepted beat, so gaps on the input stall it. After the last beat the chain runs on by itself until every operand has crossed every cell. The finished elements then leave through the leftmost cell by shifting right-to-left along the chain, one row of the product at a time. A one-cycle done flag follows the final accepted result.

Top module: `systolic_matmul`

## Requirements
- R1: While reset is held and on the first cycle after it is released, inReady, outValid and done are all low.
- R2: A start pulse sampled while idle raises inReady on the next cycle and clears every accumulator, so the results of a run never depend on an earlier run.
- R3: Beat m (0 to N*N-1, accepted when inValid and inReady are both high) carries A[m mod N][m div N] on inA and B[m div N][m mod N] on inB. After the N*N-th beat, inReady stays low until the next start. inReady and outValid are never high together.
- R4: Each result is the exact sum of the N signed products, as a 40-bit signed value, with no overflow even when every operand is -32768 or 32767.
- R5: Results appear in row-major order: C[0][0], C[0][1], and so on up to C[N-1][N-1].
- R6: While outValid is high and outReady is low, outValid stays high on the next cycle and outData does not change.
- R7: done is high for exactly one cycle, the cycle after the clock edge that accepts the N*N-th result. The block is then idle, with inReady and outValid both low.
- R8: A start pulse that arrives while operands are being loaded, or while results are being drained, has no effect on the handshakes or on the results.
- R9: Idle cycles inserted between operand beats leave every result unchanged.
- R10: outValid first rises 2*N clock edges after the edge that accepts the last operand beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a new product when idle |
| inValid | input | 1 | Operand beat present |
| inReady | output | 1 | Operand beat accepted this cycle when inValid is high |
| inA | input | DW | Signed element of A |
| inB | input | DW | Signed element of B |
| outValid | output | 1 | Result element present |
| outReady | input | 1 | Downstream takes the result |
| outData | output | AW | Signed result element |
| done | output | 1 | One-cycle pulse after the final result is taken |

## Verification
Two faults show only in the values, not in the handshakes. A stationary B element captured in the wrong step, or swapped at the wrong moment, corrupts an entire product column. A misrouted row tag corrupts a whole row. Either one first becomes visible on the first drained row, 2*N edges after the last operand. A fault in how the chain advances, such as stepping on idle input cycles, is only exposed by runs that have input gaps. Timing faults in the control appear sooner: a miscounted flush moves the first outValid away from edge 2*N, and a miscounted drain moves the done pulse or leaves results missing or extra when done arrives.

// File: rtl/smm_pkg.sv
package smm_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_FLUSH,
    S_PRIME,
    S_DRAIN
  } phase_e;

  typedef struct packed {
    logic clear;     // wipe accumulators and lane valid bits
    logic step;      // advance the operand chain by one cell
    logic bLive;     // the stepping beat carries a fresh input pair
    logic loadRow;   // copy one product row into the drain chain
    logic shiftOut;  // move the drain chain one cell left
  } strobes_t;

endpackage

// File: rtl/smm_cell.sv
module smm_cell #(
  parameter int DW  = 16,
  parameter int AW  = 40,
  parameter int DIM = 16,
  parameter int IDX = 0,
  localparam int IW = $clog2(DIM)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clear,
  input  logic                 step,
  input  logic signed [DW-1:0] bIn,
  input  logic [IW-1:0]        bColIn,
  input  logic                 bVldIn,
  input  logic signed [DW-1:0] aIn,
  input  logic [IW-1:0]        aRowIn,
  input  logic                 aVldIn,
  input  logic [IW-1:0]        rowSel,
  output logic signed [AW-1:0] accOut
);

  logic signed [DW-1:0]   bNext;
  logic signed [DW-1:0]   bCur;
  logic signed [DW-1:0]   bUse;
  logic signed [2*DW-1:0] prod;
  logic signed [AW-1:0]   prodExt;
  logic signed [AW-1:0]   acc [DIM];
  logic                   ownCol;
  logic                   newPhase;

  assign ownCol   = bVldIn && (bColIn == IW'(IDX));
  assign newPhase = aRowIn == '0;
  // the first A element of a phase meets the B value captured in the previous window
  assign bUse     = newPhase ? bNext : bCur;
  assign prod     = $signed({{DW{aIn[DW-1]}}, aIn}) * $signed({{DW{bUse[DW-1]}}, bUse});
  assign prodExt  = $signed({{(AW-2*DW){prod[2*DW-1]}}, prod});
  assign accOut   = acc[rowSel];

  always_ff @(posedge clk) begin
    if (!rstN || clear) begin
      bNext <= '0;
      bCur  <= '0;
      for (int i = 0; i < DIM; i++) acc[i] <= '0;
    end else if (step) begin
      if (ownCol) bNext <= bIn;
      if (aVldIn) begin
        if (newPhase) bCur <= bNext;
        acc[aRowIn] <= acc[aRowIn] + prodExt;
      end
    end
  end

endmodule

// File: rtl/smm_datapath.sv
module smm_datapath
  import smm_pkg::*;
#(
  parameter int DW  = 16,
  parameter int AW  = 40,
  parameter int DIM = 16,
  localparam int IW = $clog2(DIM)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobes_t             st,
  input  logic [IW-1:0]        rowSel,
  input  logic signed [DW-1:0] inA,
  input  logic signed [DW-1:0] inB,
  output logic signed [AW-1:0] outData
);

  // feeder: A elements wait DIM steps so each cell holds its B before they arrive
  logic [IW-1:0]        beatIdx;
  logic signed [DW-1:0] aLVal [DIM];
  logic [IW-1:0]        aLRow [DIM];
  logic                 aLVld [DIM];

  always_ff @(posedge clk) begin
    if (!rstN || st.clear) begin
      beatIdx <= '0;
      for (int i = 0; i < DIM; i++) begin
        aLVal[i] <= '0;
        aLRow[i] <= '0;
        aLVld[i] <= 1'b0;
      end
    end else if (st.step) begin
      aLVal[0] <= inA;
      aLRow[0] <= beatIdx;
      aLVld[0] <= st.bLive;
      for (int i = 1; i < DIM; i++) begin
        aLVal[i] <= aLVal[i-1];
        aLRow[i] <= aLRow[i-1];
        aLVld[i] <= aLVld[i-1];
      end
      if (st.bLive) beatIdx <= (beatIdx == IW'(DIM-1)) ? '0 : beatIdx + IW'(1);
    end
  end

  // cell inputs: cell 0 from the feeder, cell g from the register behind cell g-1
  logic signed [DW-1:0] cB    [DIM];
  logic [IW-1:0]        cBCol [DIM];
  logic                 cBVld [DIM];
  logic signed [DW-1:0] cA    [DIM];
  logic [IW-1:0]        cARow [DIM];
  logic                 cAVld [DIM];

  logic signed [DW-1:0] pB    [DIM-1];
  logic [IW-1:0]        pBCol [DIM-1];
  logic                 pBVld [DIM-1];
  logic signed [DW-1:0] pA    [DIM-1];
  logic [IW-1:0]        pARow [DIM-1];
  logic                 pAVld [DIM-1];

  always_comb begin
    cB[0]    = inB;
    cBCol[0] = beatIdx;
    cBVld[0] = st.bLive;
    cA[0]    = aLVal[DIM-1];
    cARow[0] = aLRow[DIM-1];
    cAVld[0] = aLVld[DIM-1];
    for (int i = 1; i < DIM; i++) begin
      cB[i]    = pB[i-1];
      cBCol[i] = pBCol[i-1];
      cBVld[i] = pBVld[i-1];
      cA[i]    = pA[i-1];
      cARow[i] = pARow[i-1];
      cAVld[i] = pAVld[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || st.clear) begin
      for (int i = 0; i < DIM-1; i++) begin
        pB[i]    <= '0;
        pBCol[i] <= '0;
        pBVld[i] <= 1'b0;
        pA[i]    <= '0;
        pARow[i] <= '0;
        pAVld[i] <= 1'b0;
      end
    end else if (st.step) begin
      for (int i = 0; i < DIM-1; i++) begin
        pB[i]    <= cB[i];
        pBCol[i] <= cBCol[i];
        pBVld[i] <= cBVld[i];
        pA[i]    <= cA[i];
        pARow[i] <= cARow[i];
        pAVld[i] <= cAVld[i];
      end
    end
  end

  logic signed [AW-1:0] accRow [DIM];

  for (genvar g = 0; g < DIM; g++) begin : gCell
    smm_cell #(.DW(DW), .AW(AW), .DIM(DIM), .IDX(g)) cell_i (
      .clk    (clk),
      .rstN   (rstN),
      .clear  (st.clear),
      .step   (st.step),
      .bIn    (cB[g]),
      .bColIn (cBCol[g]),
      .bVldIn (cBVld[g]),
      .aIn    (cA[g]),
      .aRowIn (cARow[g]),
      .aVldIn (cAVld[g]),
      .rowSel (rowSel),
      .accOut (accRow[g])
    );
  end

  // drain chain: results travel right to left and leave at cell 0
  logic signed [AW-1:0] drainReg [DIM];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DIM; i++) drainReg[i] <= '0;
    end else if (st.loadRow) begin
      for (int i = 0; i < DIM; i++) drainReg[i] <= accRow[i];
    end else if (st.shiftOut) begin
      for (int i = 0; i < DIM-1; i++) drainReg[i] <= drainReg[i+1];
      drainReg[DIM-1] <= '0;
    end
  end

  assign outData = drainReg[0];

endmodule

// File: rtl/smm_control.sv
module smm_control
  import smm_pkg::*;
#(
  parameter int DIM = 16,
  localparam int IW = $clog2(DIM),
  localparam int LOAD_LAST  = DIM*DIM - 1,
  localparam int FLUSH_LAST = DIM*DIM + 2*DIM - 2,
  localparam int CW = $clog2(FLUSH_LAST + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          inValid,
  output logic          inReady,
  output logic          outValid,
  input  logic          outReady,
  output logic          done,
  output strobes_t      st,
  output logic [IW-1:0] rowSel
);

  phase_e        state;
  logic [CW-1:0] stepCnt;
  logic [IW-1:0] colCnt;
  logic [IW-1:0] rowCnt;
  logic          accept;
  logic          take;
  logic          rowEnd;
  logic          lastOut;

  assign inReady  = state == S_LOAD;
  assign outValid = state == S_DRAIN;
  assign accept   = inReady && inValid;
  assign take     = outValid && outReady;
  assign rowEnd   = colCnt == IW'(DIM-1);
  assign lastOut  = take && rowEnd && (rowCnt == IW'(DIM-1));

  always_comb begin
    st.clear    = (state == S_IDLE) && start;
    st.step     = accept || (state == S_FLUSH);
    st.bLive    = accept;
    st.loadRow  = (state == S_PRIME) || (take && rowEnd && !lastOut);
    st.shiftOut = take && !rowEnd;
    rowSel      = (state == S_PRIME) ? '0 : rowCnt + IW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepCnt <= '0;
      colCnt  <= '0;
      rowCnt  <= '0;
      done    <= 1'b0;
    end else begin
      done <= lastOut;
      unique case (state)
        S_IDLE: if (start) begin
          state   <= S_LOAD;
          stepCnt <= '0;
        end
        S_LOAD: if (accept) begin
          stepCnt <= stepCnt + CW'(1);
          if (stepCnt == CW'(LOAD_LAST)) state <= S_FLUSH;
        end
        S_FLUSH: begin
          stepCnt <= stepCnt + CW'(1);
          if (stepCnt == CW'(FLUSH_LAST)) state <= S_PRIME;
        end
        S_PRIME: begin
          colCnt <= '0;
          rowCnt <= '0;
          state  <= S_DRAIN;
        end
        S_DRAIN: if (take) begin
          if (rowEnd) begin
            colCnt <= '0;
            rowCnt <= rowCnt + IW'(1);
            if (lastOut) state <= S_IDLE;
          end else begin
            colCnt <= colCnt + IW'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/systolic_matmul.sv
module systolic_matmul
  import smm_pkg::*;
#(
  parameter int DIM = 16,
  parameter int DW  = 16,
  parameter int AW  = 40
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          inValid,
  output logic          inReady,
  input  logic [DW-1:0] inA,
  input  logic [DW-1:0] inB,
  output logic          outValid,
  input  logic          outReady,
  output logic [AW-1:0] outData,
  output logic          done
);

  localparam int IW = $clog2(DIM);

  strobes_t      st;
  logic [IW-1:0] rowSel;

  smm_control #(.DIM(DIM)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .inValid  (inValid),
    .inReady  (inReady),
    .outValid (outValid),
    .outReady (outReady),
    .done     (done),
    .st       (st),
    .rowSel   (rowSel)
  );

  smm_datapath #(.DW(DW), .AW(AW), .DIM(DIM)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .st      (st),
    .rowSel  (rowSel),
    .inA     (inA),
    .inB     (inB),
    .outData (outData)
  );

endmodule

// File: rtl/smm_checker.sv
module smm_checker #(
  parameter int DIM = 16,
  parameter int AW  = 40
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic          inValid,
  input logic          inReady,
  input logic          outValid,
  input logic          outReady,
  input logic [AW-1:0] outData,
  input logic          done
);

  localparam int NW = $clog2(DIM*DIM + 1);

  logic [NW-1:0] outCnt;

  always_ff @(posedge clk) begin
    if (!rstN || done) outCnt <= '0;
    else if (outValid && outReady) outCnt <= outCnt + NW'(1);
  end

  AST_LOAD_DRAIN_APART: assert property (@(posedge clk) disable iff (!rstN) !(inReady && outValid)); // R3
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN) (outValid && !outReady) |=> (outValid && $stable(outData))); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN) done |=> !done); // R7
  AST_DONE_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rstN) done |-> $past(outValid && outReady)); // R7
  AST_DONE_COUNT: assert property (@(posedge clk) disable iff (!rstN) done |-> (outCnt == NW'(DIM*DIM))); // R7
  AST_START_IGNORED_DRAIN: assert property (@(posedge clk) disable iff (!rstN) (outValid && !outReady && start) |=> outValid); // R8
  AST_START_IGNORED_LOAD: assert property (@(posedge clk) disable iff (!rstN) (inReady && !inValid && start) |=> inReady); // R8

endmodule

bind systolic_matmul smm_checker #(.DIM(DIM), .AW(AW)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .outData  (outData),
  .done     (done)
);

// File: tb/systolic_matmul_tb_top.sv
module systolic_matmul_tb_top;

  localparam int DIM = 16;
  localparam int DW  = 16;
  localparam int AW  = 40;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          inValid = 1'b0;
  logic          inReady;
  logic [DW-1:0] inA = '0;
  logic [DW-1:0] inB = '0;
  logic          outValid;
  logic          outReady = 1'b0;
  logic [AW-1:0] outData;
  logic          done;

  always #10 clk = ~clk;  // 50 MHz

  systolic_matmul #(.DIM(DIM), .DW(DW), .AW(AW)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .inValid(inValid), .inReady(inReady),
    .inA(inA), .inB(inB), .outValid(outValid), .outReady(outReady),
    .outData(outData), .done(done)
  );

  int     checks = 0;
  int     fails = 0;
  longint expQ[$];
  int     matA[DIM][DIM];
  int     matB[DIM][DIM];
  bit     randReady = 1'b0;
  bit     holdOff = 1'b0;
  string  curTag = "R4";

  function automatic void chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endfunction

  // monitor: drives outReady, pops the scoreboard on each transfer
  bit            holdPrev = 1'b0;
  logic [AW-1:0] prevData = '0;
  bit            lastPopped = 1'b0;
  bit            doneSecond = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (holdPrev) chk(outValid && (outData == prevData), "R6", longint'($signed(outData)), longint'($signed(prevData)));
      if (lastPopped) begin
        chk(done == 1'b1, "R7", longint'(done), 1);
        lastPopped = 1'b0;
        doneSecond = 1'b1;
      end else if (doneSecond) begin
        chk(done == 1'b0, "R7", longint'(done), 0);
        doneSecond = 1'b0;
      end
      outReady = holdOff ? 1'b0 : (randReady ? ($urandom_range(0, 2) != 0) : 1'b1);
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R5", longint'($signed(outData)), 0);
        end else begin
          longint e;
          e = expQ.pop_front();
          chk(longint'($signed(outData)) == e, curTag, longint'($signed(outData)), e);
          if (expQ.size() == 0) lastPopped = 1'b1;
        end
      end
      holdPrev = outValid && !outReady;
      prevData = outData;
    end
  end

  task automatic fill(int kind);
    for (int r = 0; r < DIM; r++) begin
      for (int c = 0; c < DIM; c++) begin
        case (kind)
          1: begin matA[r][c] = -32768; matB[r][c] = -32768; end
          2: begin matA[r][c] = 32767;  matB[r][c] = -32768; end
          3: begin matA[r][c] = (r == c) ? 1 : 0; matB[r][c] = int'($urandom_range(0, 65535)) - 32768; end
          default: begin
            matA[r][c] = int'($urandom_range(0, 65535)) - 32768;
            matB[r][c] = int'($urandom_range(0, 65535)) - 32768;
          end
        endcase
      end
    end
  endtask

  task automatic runMatrix(int kind, int gapPct, bit bp, bit poke);
    int edges;
    fill(kind);
    for (int i = 0; i < DIM; i++) begin
      for (int j = 0; j < DIM; j++) begin
        longint s = 0;
        for (int k = 0; k < DIM; k++) s += longint'(matA[i][k]) * longint'(matB[k][j]);
        expQ.push_back(s);
      end
    end
    @(posedge clk);
    randReady = bp;
    curTag = (kind == 3) ? "R5" : ((gapPct > 0) ? "R9" : "R4");
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(inReady == 1'b1, "R2", longint'(inReady), 1);
    for (int m = 0; m < DIM*DIM; m++) begin
      int k = m / DIM;
      int t = m % DIM;
      while ($urandom_range(0, 99) < gapPct) begin
        inValid = 1'b0;
        start = poke && (m == 40);
        @(negedge clk);
        start = 1'b0;
        chk(inReady == 1'b1, "R8", longint'(inReady), 1);
      end
      inValid = 1'b1;
      inA = DW'(matA[t][k]);  // beat m: A[m mod N][m div N]
      inB = DW'(matB[k][t]);  //         B[m div N][m mod N]
      while (!inReady) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
    end
    inValid = 1'b0;
    chk(inReady == 1'b0, "R3", longint'(inReady), 0);
    edges = 0;
    while (!outValid && edges < 4*DIM) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
    end
    chk(edges == 2*DIM, "R10", edges, 2*DIM);
    chk(inReady == 1'b0, "R3", longint'(inReady), 0);
    if (poke) begin
      @(posedge clk);
      holdOff = 1'b1;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(outValid && !inReady, "R8", longint'(outValid), 1);
      @(posedge clk);
      holdOff = 1'b0;
    end
    while (expQ.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(!outValid && !inReady, "R7", longint'(outValid) + longint'(inReady), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!inReady && !outValid && !done, "R1", longint'(inReady) + longint'(outValid) + longint'(done), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!inReady && !outValid && !done, "R1", longint'(inReady) + longint'(outValid) + longint'(done), 0);
    runMatrix(0, 0, 1'b0, 1'b0);
    runMatrix(1, 0, 1'b1, 1'b0);
    runMatrix(2, 30, 1'b1, 1'b1);
    runMatrix(3, 50, 1'b0, 1'b0);
    runMatrix(0, 20, 1'b1, 1'b1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R7 watchdog: actual 0 expected 1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule